// File: doc/BRIEF.md
# Configurable-Width SPI Master Engine

This block is a synchronous serial master. It shifts one word out on a data-out line while it shifts one word in from a data-in line. It generates a serial clock by dividing the system clock by a programmable amount. The word length is chosen at run time from 8, 16 or 32 bits. Software controls the block through a small register bus. A transfer starts as soon as a word is written into the transmit buffer. The received word is read back from the receive buffer. Slave select is not part of the block; software drives it from an ordinary output.

Software programs a configuration register with these fields:
- enable;
- master mode;
- clock idle level;
- which clock transition moves the output data;
- where the input is sampled, either the middle or the end of each bit time;
- a receive-only switch that releases the data-out line;
- the word size.

A second register holds the clock divisor. A status register reports the transmit-full, receive-full, overflow and busy flags. Clearing the enable bit stops any transfer in progress and returns the engine to its idle state.

Top module: `spi_word_master`

## Requirements
- R1: After reset every configuration field, the divisor and all status flags read zero, and `sck` is low.
- R2: A transfer produces exactly 8, 16 or 32 clock pulses. The count is set by the size field, config bits [7:6]: 00 selects 8, 01 selects 16, and 1x selects 32.
- R3: Each half period of `sck` lasts divisor+1 system clocks, so one clock pulse spans 2×(divisor+1) cycles. `sck` sits at its idle level whenever no transfer is running.
- R4: Data leaves most significant bit first, and each bit occupies two half periods. With config bit 3 at 0, the first bit is presented before the first clock edge and the data moves on active-to-idle edges. With bit 3 at 1, the data moves on idle-to-active edges.
- R5: Config bit 4 selects the input sample point. At 0, `sdi` is captured at the end of the first half of each bit time (the middle of the bit). At 1, it is captured at the end of the second half (the end of the bit). The bits captured form the received word, right-aligned.
- R6: When config bit 5 is set, `sdoOe` is low. Clocking and reception continue unchanged. `sdoOe` is high only when the engine is enabled (bit 0), in master mode (bit 1), and bit 5 is clear.
- R7: A write to the data register (address 2) while the engine is enabled and the transmit buffer is empty sets transmit-full (status bit 0). The transfer then begins on the next clock. A write while transmit-full is set is ignored.
- R8: A completed word goes to the receive buffer and sets receive-full (status bit 1). A read of address 2 with `rdEn` high clears receive-full. If a word completes while receive-full is set and no read occurs in that cycle, overflow (status bit 2) sets and the new word is discarded. If the read and the completion fall in the same cycle, the new word is accepted.
- R9: Writing 1 to status bit 2 (address 3) clears overflow. An overflow arising in the same cycle takes precedence.
- R10: While the enable bit is 0, the engine is held idle: busy (status bit 3), transmit-full, receive-full and overflow are all 0, and `sck` rests at its idle level.
- R11: Writes to the clock polarity (config bit 2) and clock edge (config bit 3) take effect only while the engine is disabled. While it is enabled, those two bits keep their values.
- R12: With master mode (config bit 1) clear, a written word stays in the transmit buffer and no transfer starts.
- R13: Config bit 2 sets the idle level of `sck`: 0 for low, 1 for high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the receive buffer at address 2) |
| addr | input | 2 | Register select: 0 config, 1 divisor, 2 data, 3 status |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register (combinational) |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the data-out pad |
| sdi | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle: the completion of a received word, and a software read that empties the receive buffer. The bench holds an unread word, then starts a second transfer. It times an `rdEn` pulse to the exact clock on which the final half period ends, using its own cycle count of the transfer. The outcome is judged by status and data: overflow must stay clear and the new word must be in the buffer. A separate run without that read must raise overflow and keep the old word. A behavioural model compares `sck`, `sdo`, `sdoOe` and `rdData` on every clock, while `sdi` toggles pseudo-randomly each cycle so that a wrong sample point shows up.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  // Register addresses
  localparam int REG_CFG  = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_DATA = 2;
  localparam int REG_STAT = 3;

  // Configuration register, bit 0 first (en) up to size in [7:6]
  typedef struct packed {
    logic [1:0] size;
    logic       txOff;
    logic       late;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic finish;
  } strobe_t;

endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl import spi_word_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int BITS_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              txFull,
  output strobe_t           strb,
  output logic [BITS_W-1:0] wordBits,
  output logic              busy,
  output logic              sck
);

  localparam int HALF_W = BITS_W;

  logic              busyQ;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [BITS_W-1:0] bitsQ;
  logic [BITS_W:0]   lastIdx;
  logic              tick;
  logic              lastHalf;

  // R2: size field decode
  always_comb begin
    case (cfg.size)
      2'b00:   wordBits = BITS_W'(DATA_W / 4);
      2'b01:   wordBits = BITS_W'(DATA_W / 2);
      default: wordBits = BITS_W'(DATA_W);
    endcase
  end

  assign lastIdx  = {bitsQ, 1'b0} - {{BITS_W{1'b0}}, 1'b1};
  assign tick     = busyQ && (divCnt == divisor);           // R3
  assign lastHalf = ({1'b0, halfCnt} == lastIdx);

  always_comb begin
    strb.clear    = !cfg.en;                                // R10
    strb.load     = cfg.en && cfg.master && !busyQ && txFull; // R7, R12
    strb.shiftOut = tick && halfCnt[0];                     // R4
    strb.sampleIn = tick && (halfCnt[0] == cfg.late);       // R5
    strb.finish   = tick && lastHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
      bitsQ   <= '0;
    end else if (!cfg.en) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
    end else if (strb.load) begin
      busyQ   <= 1'b1;
      divCnt  <= '0;
      halfCnt <= '0;
      bitsQ   <= wordBits;
    end else if (busyQ) begin
      if (tick) begin
        divCnt <= '0;
        if (lastHalf) busyQ <= 1'b0;
        else          halfCnt <= halfCnt + {{(HALF_W-1){1'b0}}, 1'b1};
      end else begin
        divCnt <= divCnt + {{(DIV_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign busy = busyQ;
  // R13, R4: active level in odd halves (cpha 0) or even halves (cpha 1)
  assign sck  = cfg.cpol ^ (busyQ & (halfCnt[0] ^ cfg.cpha));

endmodule

// File: rtl/spi_word_dp.sv
module spi_word_dp import spi_word_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2,
  parameter int BITS_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  strobe_t           strb,
  input  logic [BITS_W-1:0] wordBits,
  input  logic              busy,
  output cfg_t              cfg,
  output logic [DIV_W-1:0]  divisor,
  output logic              txFull,
  output logic              rxFull,
  output logic              ovf
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(REG_DIV);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t              cfgQ;
  cfg_t              cfgNew;
  logic [DIV_W-1:0]  divQ;
  logic [DATA_W-1:0] txBufQ, txShiftQ, rxShiftQ, rxBufQ, rxWord;
  logic              txFullQ, rxFullQ, ovfQ;
  logic              wrTx, rdRx, clrOvf, rxFullKeep;

  assign cfgNew     = cfg_t'(wrData[CFG_W-1:0]);
  assign wrTx       = wrEn && (addr == A_DATA) && cfgQ.en && !txFullQ; // R7
  assign rdRx       = rdEn && (addr == A_DATA);
  assign clrOvf     = wrEn && (addr == A_STAT) && wrData[2];          // R9
  assign rxFullKeep = rxFullQ && !rdRx;
  assign rxWord     = strb.sampleIn ? {rxShiftQ[DATA_W-2:0], sdi} : rxShiftQ;

  // Configuration and divisor; R11 locks polarity and edge while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      divQ <= '0;
    end else begin
      if (wrEn && (addr == A_CFG)) begin
        cfgQ <= cfgNew;
        if (cfgQ.en) begin
          cfgQ.cpol <= cfgQ.cpol;
          cfgQ.cpha <= cfgQ.cpha;
        end
      end
      if (wrEn && (addr == A_DIV)) divQ <= wrData[DIV_W-1:0];
    end
  end

  // Transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBufQ   <= '0;
      txFullQ  <= 1'b0;
      txShiftQ <= '0;
    end else if (strb.clear) begin
      txFullQ  <= 1'b0;
      txShiftQ <= '0;
    end else begin
      if (strb.load) begin
        txShiftQ <= txBufQ << (DATA_W - int'(wordBits));
        txFullQ  <= 1'b0;
      end else if (strb.shiftOut) begin
        txShiftQ <= {txShiftQ[DATA_W-2:0], 1'b0};
      end
      if (wrTx) begin
        txBufQ  <= wrData;
        txFullQ <= 1'b1;
      end
    end
  end

  // Receive side, R8 and R9
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      rxBufQ   <= '0;
      rxFullQ  <= 1'b0;
      ovfQ     <= 1'b0;
    end else if (strb.clear) begin
      rxShiftQ <= '0;
      rxBufQ   <= '0;
      rxFullQ  <= 1'b0;
      ovfQ     <= 1'b0;
    end else begin
      if (strb.load)          rxShiftQ <= '0;
      else if (strb.sampleIn) rxShiftQ <= rxWord;
      rxFullQ <= rxFullKeep;
      if (clrOvf) ovfQ <= 1'b0;
      if (strb.finish) begin
        if (rxFullKeep) begin
          ovfQ <= 1'b1;
        end else begin
          rxBufQ  <= rxWord;
          rxFullQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CFG:   rdData = {{(DATA_W-CFG_W){1'b0}}, cfgQ};
      A_DIV:   rdData = {{(DATA_W-DIV_W){1'b0}}, divQ};
      A_DATA:  rdData = rxBufQ;
      default: rdData = {{(DATA_W-4){1'b0}}, busy, ovfQ, rxFullQ, txFullQ};
    endcase
  end

  assign sdo     = busy ? txShiftQ[DATA_W-1] : 1'b0;     // R4
  assign sdoOe   = cfgQ.en && cfgQ.master && !cfgQ.txOff; // R6
  assign cfg     = cfgQ;
  assign divisor = divQ;
  assign txFull  = txFullQ;
  assign rxFull  = rxFullQ;
  assign ovf     = ovfQ;

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master import spi_word_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sck,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              sdi
);

  localparam int BITS_W = $clog2(DATA_W) + 1;

  cfg_t              cfgW;
  strobe_t           strbW;
  logic [DIV_W-1:0]  divW;
  logic [BITS_W-1:0] bitsW;
  logic              busyW, txFullW, rxFullW, ovfW, rdRxW;

  assign rdRxW = rdEn && (addr == ADDR_W'(REG_DATA));

  spi_word_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BITS_W(BITS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfgW), .divisor(divW), .txFull(txFullW),
    .strb(strbW), .wordBits(bitsW), .busy(busyW), .sck(sck)
  );

  spi_word_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .BITS_W(BITS_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe),
    .strb(strbW), .wordBits(bitsW), .busy(busyW), .cfg(cfgW), .divisor(divW),
    .txFull(txFullW), .rxFull(rxFullW), .ovf(ovfW)
  );

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic clk,
  input logic rstN,
  input logic en,
  input logic master,
  input logic cpol,
  input logic txOff,
  input logic sdoOe,
  input logic busy,
  input logic load,
  input logic finish,
  input logic txFull,
  input logic rxFull,
  input logic ovf,
  input logic rdRx
);

  assert_overflow_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (finish && rxFull && !rdRx) |=> ovf);

  assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !txFull);

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!busy && !txFull && !rxFull && !ovf));

  assert_release_sdo_R6: assert property (@(posedge clk) disable iff (!rstN)
    txOff |-> !sdoOe);

  assert_cpol_locked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (en && $past(en)) |-> $stable(cpol));

  assert_no_start_slave_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!master && !busy) |=> !busy);

endmodule

bind spi_word_master spi_word_master_chk u_chk (
  .clk(clk), .rstN(rstN), .en(cfgW.en), .master(cfgW.master), .cpol(cfgW.cpol),
  .txOff(cfgW.txOff), .sdoOe(sdoOe), .busy(busyW), .load(strbW.load),
  .finish(strbW.finish), .txFull(txFullW), .rxFull(rxFullW), .ovf(ovfW),
  .rdRx(rdRxW)
);

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addrI = 2'd3;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sck, sdo, sdoOe;
  logic        sdi = 1'b0;

  int checks = 0, fails = 0, cyc = 0, pulses = 0;
  logic prevSck = 1'b0;
  logic finished = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  // Behavioural model state
  logic mEn, mMas, mCpol, mCpha, mLate, mTxOff;
  logic [1:0] mSize;
  int mDiv, mT, mN;
  logic mAct, mTxFull, mRxFull, mOvf;
  logic [31:0] mTxBuf, mTxWord, mRx, mRxBuf;
  logic enPre, txFullPre, doneNow, startNow, rxKeep;
  int h;

  always #10 clk = ~clk;

  spi_word_master u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addrI),
    .wrData(wrData), .rdData(rdData), .sck(sck), .sdo(sdo), .sdoOe(sdoOe), .sdi(sdi)
  );

  function automatic int sizeBits(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  function automatic logic [31:0] cfgWord(input logic en, ms, cp, ch, lt, tx, input logic [1:0] sz);
    return {24'd0, sz, tx, lt, ch, cp, ms, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-accurate behavioural reference
  always @(posedge clk) begin
    if (!rstN) begin
      {mEn, mMas, mCpol, mCpha, mLate, mTxOff} = '0;
      mSize = 2'b00; mDiv = 0; mT = 0; mN = 8;
      {mAct, mTxFull, mRxFull, mOvf} = '0;
      mTxBuf = '0; mTxWord = '0; mRx = '0; mRxBuf = '0;
    end else begin
      enPre = mEn; txFullPre = mTxFull; doneNow = 0; startNow = 0;
      if (!enPre) begin
        mTxFull = 0; mRxFull = 0; mOvf = 0; mAct = 0; mRxBuf = '0;
      end else begin
        if (mAct) begin
          h = mT / (mDiv + 1);
          if (mT % (mDiv + 1) == mDiv) begin
            if (((h % 2) == 1) == mLate) mRx = {mRx[30:0], sdi};
            if (h == 2 * mN - 1) begin mAct = 0; doneNow = 1; end
          end
          mT++;
        end else if (mTxFull && mMas) begin
          mAct = 1; mT = 0; mTxWord = mTxBuf; mN = sizeBits(mSize); mRx = '0; startNow = 1;
        end
        rxKeep = mRxFull && !(rdEn && addrI == 2'd2);
        if (wrEn && addrI == 2'd3 && wrData[2]) mOvf = 0;
        if (doneNow) begin
          if (rxKeep) mOvf = 1;
          else begin mRxBuf = mRx; rxKeep = 1; end
        end
        mRxFull = rxKeep;
        if (startNow) mTxFull = 0;
        if (wrEn && addrI == 2'd2 && !txFullPre) begin mTxFull = 1; mTxBuf = wrData; end
      end
      if (wrEn && addrI == 2'd0) begin
        mEn = wrData[0]; mMas = wrData[1]; mLate = wrData[4]; mTxOff = wrData[5];
        mSize = wrData[7:6];
        if (!enPre) begin mCpol = wrData[2]; mCpha = wrData[3]; end
      end
      if (wrEn && addrI == 2'd1) mDiv = int'(wrData[15:0]);
    end
  end

  function automatic logic [31:0] expRd();
    case (addrI)
      2'd0: return {24'd0, mSize, mTxOff, mLate, mCpha, mCpol, mMas, mEn};
      2'd1: return 32'(mDiv);
      2'd2: return mRxBuf;
      default: return {28'd0, mAct, mOvf, mRxFull, mTxFull};
    endcase
  endfunction

  // Per-cycle comparison and pulse counting
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int hh;
      logic eSck, eSdo;
      hh = mT / (mDiv + 1);
      eSck = mCpol ^ (mAct & (((hh % 2) == 1) ^ mCpha));
      eSdo = mAct ? mTxWord[mN - 1 - hh / 2] : 1'b0;
      chk("R3 R13 sck", 32'(sck), 32'(eSck));
      chk("R4 sdo", 32'(sdo), 32'(eSdo));
      chk("R6 sdoOe", 32'(sdoOe), 32'(mEn & mMas & !mTxOff));
      chk("R8 rdData", rdData, expRd());
      if (sck !== prevSck) begin
        if (sck !== mCpol) pulses++;
        prevSck = sck;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    sdi = lfsr[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1; wrEn = 1; addrI = a; wrData = d;
    @(negedge clk); #1; wrEn = 0; addrI = 2'd3;
  endtask

  task automatic rdPop();
    @(negedge clk); #1; rdEn = 1; addrI = 2'd2;
    @(negedge clk); #1; rdEn = 0; addrI = 2'd3;
  endtask

  task automatic expectReg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1; addrI = a;
    @(negedge clk); #2; chk(tag, rdData, exp); addrI = 2'd3;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!mAct && !mTxFull) break;
    end
    #2;
  endtask

  task automatic xfer(input logic [31:0] d, input int nBits, input string tag);
    pulses = 0;
    wr(2'd2, d);
    waitDone();
    chk(tag, 32'(pulses), 32'(nBits));
  endtask

  initial begin
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #2;
    chk("R1 status", rdData, 32'd0);
    chk("R1 sck", 32'(sck), 32'd0);
    expectReg(2'd0, 32'd0, "R1 config");

    // 8-bit, mid sample, changes on active-to-idle
    wr(2'd1, 32'd1);
    wr(2'd0, cfgWord(1, 1, 0, 0, 0, 0, 2'b00));
    xfer(32'h0000_00A5, 8, "R2 pulses 8");
    expectReg(2'd2, mRxBuf, "R5 rx mid");
    rdPop();
    expectReg(2'd3, 32'd0, "R8 read clears rxFull");

    // R11: polarity write while enabled is ignored
    wr(2'd0, cfgWord(1, 1, 1, 1, 0, 0, 2'b00));
    expectReg(2'd0, cfgWord(1, 1, 0, 0, 0, 0, 2'b00), "R11 cfg locked");
    chk("R11 sck idle", 32'(sck), 32'd0);

    // 16-bit, late sample, changes on idle-to-active
    wr(2'd0, cfgWord(0, 1, 0, 1, 1, 0, 2'b01));
    wr(2'd0, cfgWord(1, 1, 0, 1, 1, 0, 2'b01));
    xfer(32'h0000_C3E1, 16, "R2 pulses 16");
    expectReg(2'd2, mRxBuf, "R5 rx late");
    rdPop();

    // 32-bit, idle high, divisor 2, receive-only
    wr(2'd0, cfgWord(0, 1, 1, 0, 0, 1, 2'b10));
    wr(2'd1, 32'd2);
    wr(2'd0, cfgWord(1, 1, 1, 0, 0, 1, 2'b10));
    @(negedge clk); #2;
    chk("R13 idle high", 32'(sck), 32'd1);
    chk("R6 released", 32'(sdoOe), 32'd0);
    xfer(32'h8123_4567, 32, "R2 pulses 32");
    expectReg(2'd3, 32'd2, "R6 rx continues");
    rdPop();

    // R7: second write during a pending word is ignored
    wr(2'd0, cfgWord(0, 1, 0, 0, 0, 0, 2'b00));
    wr(2'd1, 32'd0);
    wr(2'd0, cfgWord(1, 1, 0, 0, 0, 0, 2'b00));
    pulses = 0;
    wr(2'd2, 32'h11);
    wr(2'd2, 32'h22);
    wr(2'd2, 32'h33);
    waitDone();
    chk("R7 two transfers only", 32'(pulses), 32'd16);

    // R8: overflow, old word kept
    saved = mRxBuf;
    xfer(32'h5A, 8, "R2 pulses ovf");
    expectReg(2'd3, 32'd6, "R8 overflow set");
    expectReg(2'd2, saved, "R8 old word kept");
    wr(2'd3, 32'd4);
    expectReg(2'd3, 32'd2, "R9 overflow cleared");

    // R8: read in the completion cycle accepts the new word
    wr(2'd2, 32'h96);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (mAct && mT == 2 * mN * (mDiv + 1) - 1) break;
    end
    #1; rdEn = 1; addrI = 2'd2;
    @(negedge clk); #1; rdEn = 0; addrI = 2'd3;
    @(negedge clk); #2;
    chk("R8 same-cycle status", rdData, 32'd2);
    rdPop();

    // R12: no start without master mode
    wr(2'd0, cfgWord(1, 0, 0, 0, 0, 0, 2'b00));
    wr(2'd2, 32'h77);
    repeat (20) @(negedge clk);
    #2 chk("R12 held", rdData, 32'd1);
    wr(2'd0, cfgWord(1, 1, 0, 0, 0, 0, 2'b00));
    waitDone();
    chk("R12 sent after master", 32'(mRxFull), 32'd1);

    // R10: disable mid-transfer
    wr(2'd1, 32'd3);
    wr(2'd2, 32'hF0);
    repeat (10) @(negedge clk);
    wr(2'd0, cfgWord(0, 1, 0, 0, 0, 0, 2'b00));
    @(negedge clk); #2;
    chk("R10 status", rdData, 32'd0);
    chk("R10 sck idle", 32'(sck), 32'd0);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule